// File: doc/BRIEF.md
# Two-Way Mailbox Register Bank

This block is a small register bank shared by two agents: a host that reaches it through a byte-addressed register bus, and a local microcontroller on its own bus. Each agent has its own single-cycle read and write strobes, address and data. The bank holds two groups of interrupting mailboxes, one for each direction. The host fills the four downstream mailboxes for the microcontroller. The microcontroller fills the four upstream mailboxes for the host. Eight scratch registers are written and read the same way, but writing them never interrupts the other side.

Each mailbox has a sticky pending bit. The receiving side owns an enable mask for its four pending bits. Its interrupt output is high while any enabled pending bit is set. When the receiving side reads a mailbox, that mailbox's pending bit clears. Both sides use the same address map. Each agent may write only the registers of its own direction. A write to the other direction's registers is dropped, and an unmapped read returns zero.

Top module: `mbox_regfile`

## Requirements
- R1: After reset every mailbox, scratch register, pending bit and enable mask is zero, both read data outputs are zero and both interrupt outputs are low.
- R2: Address map, the same on both sides (5-bit addresses): 0x00-0x03 downstream mailboxes, 0x04-0x07 upstream mailboxes, 0x08-0x0B downstream scratch, 0x0C-0x0F upstream scratch. Either side may read any of them. The value appears on that side's read data output on the cycle after the read strobe and holds until that side's next read.
- R3: A host write to downstream mailbox k sets downstream pending bit k. `l_irq_o` is high exactly when some pending bit k is set and bit k of the local enable mask is set. The local side writes this mask at address 0x10, bits 3:0.
- R4: A local write to upstream mailbox k sets upstream pending bit k. `h_irq_o` is high exactly when some such pending bit is set and bit k of the host enable mask is set. The host side writes this mask at address 0x10, bits 3:0.
- R5: A write to any scratch register never changes a pending bit.
- R6: Writes to another direction's registers are ignored: host writes to 0x04-0x07 and 0x0C-0x0F, and local writes to 0x00-0x03 and 0x08-0x0B.
- R7: A read of mailbox k by the receiving side clears that mailbox's pending bit. A read by the writing side leaves it set.
- R8: If a mailbox write and a clearing read of the same mailbox happen in the same cycle, the pending bit ends up set. The read returns the value held before the write.
- R9: On each side, address 0x11 reads that side's incoming pending bits in bits 3:0 and does not clear them. Address 0x10 reads back that side's enable mask.
- R10: Reads of addresses 0x12-0x1F return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_wr_i | input | 1 | Host write strobe |
| h_rd_i | input | 1 | Host read strobe |
| h_addr_i | input | 5 | Host register address |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data, registered |
| h_irq_o | output | 1 | Interrupt to host |
| l_wr_i | input | 1 | Local write strobe |
| l_rd_i | input | 1 | Local read strobe |
| l_addr_i | input | 5 | Local register address |
| l_wdata_i | input | 8 | Local write data |
| l_rdata_o | output | 8 | Local read data, registered |
| l_irq_o | output | 1 | Interrupt to local microcontroller |

## Verification
The properties assume that strobes and addresses are stable across each rising edge. They allow a read and a write on the same side in one cycle, but the stimulus never issues one. The scratch and ignored-write properties are guarded by the absence of a clearing read or owner write from the other side in that cycle. The stimulus drives every strobe for exactly one cycle from the falling edge. It creates a same-mailbox collision only once, on purpose, to exercise the write-wins rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NMB = 4;
  localparam int unsigned AW  = 5;
  localparam int unsigned IW  = $clog2(NMB);

  typedef enum logic [2:0] {
    K_DMB, K_UMB, K_DSC, K_USC, K_EN, K_STAT, K_NONE
  } reg_kind_e;

  function automatic reg_kind_e decode(input logic [AW-1:0] a);
    reg_kind_e k;
    if (!a[4]) begin
      case (a[3:2])
        2'd0:    k = K_DMB;
        2'd1:    k = K_UMB;
        2'd2:    k = K_DSC;
        default: k = K_USC;
      endcase
    end else if (a == 5'h10) k = K_EN;
    else if (a == 5'h11)     k = K_STAT;
    else                     k = K_NONE;
    return k;
  endfunction
endpackage

// File: rtl/mbox_dir.sv
module mbox_dir #(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_mb_i,
  input  logic                 wr_sc_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 rd_clr_i,
  input  logic [IW-1:0]        rd_idx_i,
  input  logic                 en_we_i,
  input  logic [N-1:0]         en_wdata_i,
  output logic [N-1:0][DW-1:0] mb_o,
  output logic [N-1:0][DW-1:0] sc_o,
  output logic [N-1:0]         pend_o,
  output logic [N-1:0]         en_o,
  output logic                 irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mb_o[i]   <= '0;
        sc_o[i]   <= '0;
        pend_o[i] <= 1'b0;
      end else begin
        if (wr_mb_i && wr_idx_i == IW'(i)) mb_o[i] <= wdata_i;
        if (wr_sc_i && wr_idx_i == IW'(i)) sc_o[i] <= wdata_i;
        // write beats a same-cycle clearing read
        if (wr_mb_i && wr_idx_i == IW'(i))       pend_o[i] <= 1'b1;
        else if (rd_clr_i && rd_idx_i == IW'(i)) pend_o[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= en_wdata_i;
  end

  assign irq_o = |(pend_o & en_o);
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [N-1:0][DW-1:0] dmb_i,
  input  logic [N-1:0][DW-1:0] umb_i,
  input  logic [N-1:0][DW-1:0] dsc_i,
  input  logic [N-1:0][DW-1:0] usc_i,
  input  logic [N-1:0]         en_i,
  input  logic [N-1:0]         pend_i,
  output logic [DW-1:0]        rdata_o
);
  logic [IW-1:0] idx;
  logic [DW-1:0] rd_val;

  assign idx = addr_i[IW-1:0];

  always_comb begin
    rd_val = '0;
    unique case (decode(addr_i))
      K_DMB:   rd_val = dmb_i[idx];
      K_UMB:   rd_val = umb_i[idx];
      K_DSC:   rd_val = dsc_i[idx];
      K_USC:   rd_val = usc_i[idx];
      K_EN:    rd_val[N-1:0] = en_i;
      K_STAT:  rd_val[N-1:0] = pend_i;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_wr_i,
  input  logic          h_rd_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  output logic          h_irq_o,
  input  logic          l_wr_i,
  input  logic          l_rd_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_irq_o
);
  reg_kind_e h_kind, l_kind;
  logic [NMB-1:0][DW-1:0] a_mb, a_sc, b_mb, b_sc;
  logic [NMB-1:0] a_pend, a_en, b_pend, b_en;

  assign h_kind = decode(h_addr_i);
  assign l_kind = decode(l_addr_i);

  // a: host -> local
  mbox_dir #(.DW(DW), .N(NMB)) u_down (
    .clk_i, .rst_ni,
    .wr_mb_i   (h_wr_i && h_kind == K_DMB),
    .wr_sc_i   (h_wr_i && h_kind == K_DSC),
    .wr_idx_i  (h_addr_i[IW-1:0]),
    .wdata_i   (h_wdata_i),
    .rd_clr_i  (l_rd_i && l_kind == K_DMB),
    .rd_idx_i  (l_addr_i[IW-1:0]),
    .en_we_i   (l_wr_i && l_kind == K_EN),
    .en_wdata_i(l_wdata_i[NMB-1:0]),
    .mb_o      (a_mb),
    .sc_o      (a_sc),
    .pend_o    (a_pend),
    .en_o      (a_en),
    .irq_o     (l_irq_o)
  );

  // b: local -> host
  mbox_dir #(.DW(DW), .N(NMB)) u_up (
    .clk_i, .rst_ni,
    .wr_mb_i   (l_wr_i && l_kind == K_UMB),
    .wr_sc_i   (l_wr_i && l_kind == K_USC),
    .wr_idx_i  (l_addr_i[IW-1:0]),
    .wdata_i   (l_wdata_i),
    .rd_clr_i  (h_rd_i && h_kind == K_UMB),
    .rd_idx_i  (h_addr_i[IW-1:0]),
    .en_we_i   (h_wr_i && h_kind == K_EN),
    .en_wdata_i(h_wdata_i[NMB-1:0]),
    .mb_o      (b_mb),
    .sc_o      (b_sc),
    .pend_o    (b_pend),
    .en_o      (b_en),
    .irq_o     (h_irq_o)
  );

  mbox_rd_port #(.DW(DW), .N(NMB)) u_h_rd (
    .clk_i, .rst_ni,
    .rd_i(h_rd_i), .addr_i(h_addr_i),
    .dmb_i(a_mb), .umb_i(b_mb), .dsc_i(a_sc), .usc_i(b_sc),
    .en_i(b_en), .pend_i(b_pend),
    .rdata_o(h_rdata_o)
  );

  mbox_rd_port #(.DW(DW), .N(NMB)) u_l_rd (
    .clk_i, .rst_ni,
    .rd_i(l_rd_i), .addr_i(l_addr_i),
    .dmb_i(a_mb), .umb_i(b_mb), .dsc_i(a_sc), .usc_i(b_sc),
    .en_i(a_en), .pend_i(a_pend),
    .rdata_o(l_rdata_o)
  );
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 h_wr_i,
  input logic                 h_rd_i,
  input logic [4:0]           h_addr_i,
  input logic [DW-1:0]        h_rdata_o,
  input logic                 l_wr_i,
  input logic                 l_rd_i,
  input logic [4:0]           l_addr_i,
  input logic [DW-1:0]        l_rdata_o,
  input logic                 h_irq_o,
  input logic                 l_irq_o,
  input logic [N-1:0]         a_pend,
  input logic [N-1:0]         b_pend,
  input logic [N-1:0][DW-1:0] a_mb,
  input logic [N-1:0][DW-1:0] b_mb
);
  AST_DOWN_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i && h_addr_i[4:2] == 3'b000 |=> a_pend[$past(h_addr_i[1:0])]); // R3 R8

  AST_UP_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_i && l_addr_i[4:2] == 3'b001 |=> b_pend[$past(l_addr_i[1:0])]); // R4

  AST_L_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_irq_o |-> |a_pend); // R3

  AST_H_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_irq_o |-> |b_pend); // R4

  AST_SCRATCH_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i && h_addr_i[4:2] == 3'b010 && !l_rd_i |=> $stable(a_pend)); // R5

  AST_FOREIGN_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i && h_addr_i[4:2] == 3'b001 && !l_wr_i |=> $stable(b_mb)); // R6

  AST_LOCAL_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rd_i && l_addr_i[4:2] == 3'b000 && !h_wr_i |=> !a_pend[$past(l_addr_i[1:0])]); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rd_i && h_addr_i[4] && h_addr_i[3:1] != 3'b000 |=> h_rdata_o == '0); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rd_i |=> $stable(l_rdata_o)); // R2
endmodule

bind mbox_regfile mbox_regfile_chk #(.DW(DW), .N(mbox_pkg::NMB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_wr_i(h_wr_i), .h_rd_i(h_rd_i), .h_addr_i(h_addr_i), .h_rdata_o(h_rdata_o),
  .l_wr_i(l_wr_i), .l_rd_i(l_rd_i), .l_addr_i(l_addr_i), .l_rdata_o(l_rdata_o),
  .h_irq_o(h_irq_o), .l_irq_o(l_irq_o),
  .a_pend(a_pend), .b_pend(b_pend), .a_mb(a_mb), .b_mb(b_mb)
);

// File: tb/mbox_regfile_tb_top.sv
module mbox_regfile_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic h_wr_i = 0, h_rd_i = 0, l_wr_i = 0, l_rd_i = 0;
  logic [4:0] h_addr_i = '0, l_addr_i = '0;
  logic [7:0] h_wdata_i = '0, l_wdata_i = '0;
  logic [7:0] h_rdata_o, l_rdata_o;
  logic h_irq_o, l_irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] h_exp_q[$], l_exp_q[$];
  string h_tag_q[$], l_tag_q[$];

  always #10 clk_i = ~clk_i;

  mbox_regfile dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle on both buses; expected read data pushed for the monitor
  task automatic cyc(input logic hw, input logic hr, input logic [4:0] ha, input logic [7:0] hd,
                     input logic lw, input logic lr, input logic [4:0] la, input logic [7:0] ld,
                     input logic [7:0] hexp, input logic [7:0] lexp, input string tag);
    @(negedge clk_i);
    h_wr_i = hw; h_rd_i = hr; h_addr_i = ha; h_wdata_i = hd;
    l_wr_i = lw; l_rd_i = lr; l_addr_i = la; l_wdata_i = ld;
    if (hr) begin h_exp_q.push_back(hexp); h_tag_q.push_back(tag); end
    if (lr) begin l_exp_q.push_back(lexp); l_tag_q.push_back(tag); end
    @(negedge clk_i);
    h_wr_i = 0; h_rd_i = 0; l_wr_i = 0; l_rd_i = 0;
  endtask

  task automatic hwr(input logic [4:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, 0, 0, '0, '0, '0, '0, "");
  endtask
  task automatic lwr(input logic [4:0] a, input logic [7:0] d);
    cyc(0, 0, '0, '0, 1, 0, a, d, '0, '0, "");
  endtask
  task automatic hrd(input logic [4:0] a, input logic [7:0] e, input string tag);
    cyc(0, 1, a, '0, 0, 0, '0, '0, e, '0, tag);
  endtask
  task automatic lrd(input logic [4:0] a, input logic [7:0] e, input string tag);
    cyc(0, 0, '0, '0, 0, 1, a, '0, '0, e, tag);
  endtask

  // monitor: pops expected read data one cycle after each strobe
  initial begin
    forever begin
      logic hr, lr;
      @(posedge clk_i);
      hr = h_rd_i; lr = l_rd_i;
      #1;
      if (hr && h_exp_q.size() > 0) check({h_tag_q.pop_front(), " host read"}, h_rdata_o, h_exp_q.pop_front());
      if (lr && l_exp_q.size() > 0) check({l_tag_q.pop_front(), " local read"}, l_rdata_o, l_exp_q.pop_front());
    end
  end

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset h_irq", {7'd0, h_irq_o}, 8'h00);
    check("R1 reset l_irq", {7'd0, l_irq_o}, 8'h00);
    check("R1 reset h_rdata", h_rdata_o, 8'h00);
    hrd(5'h00, 8'h00, "R1");
    lrd(5'h04, 8'h00, "R1");
    lrd(5'h10, 8'h00, "R1");

    hwr(5'h00, 8'hA5);
    hwr(5'h03, 8'h3C);
    check("R3 masked irq", {7'd0, l_irq_o}, 8'h00);
    lrd(5'h11, 8'h09, "R9");
    lwr(5'h10, 8'h08);
    check("R3 enabled irq", {7'd0, l_irq_o}, 8'h01);
    lrd(5'h10, 8'h08, "R9");

    hrd(5'h00, 8'hA5, "R2");
    lrd(5'h11, 8'h09, "R7");      // writer-side read left pending
    lrd(5'h03, 8'h3C, "R2");
    check("R7 irq cleared", {7'd0, l_irq_o}, 8'h00);
    lrd(5'h11, 8'h01, "R7");

    hwr(5'h09, 8'h77);
    lrd(5'h11, 8'h01, "R5");
    lrd(5'h09, 8'h77, "R2");

    hwr(5'h05, 8'hEE);
    hwr(5'h0D, 8'hDD);
    lrd(5'h05, 8'h00, "R6");
    hrd(5'h0D, 8'h00, "R6");
    hrd(5'h11, 8'h00, "R6");
    lwr(5'h01, 8'h11);
    hrd(5'h01, 8'h00, "R6");
    lrd(5'h11, 8'h01, "R6");

    lwr(5'h06, 8'h5A);
    check("R4 masked irq", {7'd0, h_irq_o}, 8'h00);
    hwr(5'h10, 8'h04);
    check("R4 enabled irq", {7'd0, h_irq_o}, 8'h01);
    hrd(5'h06, 8'h5A, "R4");
    check("R7 host irq cleared", {7'd0, h_irq_o}, 8'h00);
    lwr(5'h0E, 8'h42);
    hrd(5'h11, 8'h00, "R5");
    hrd(5'h0E, 8'h42, "R2");

    lwr(5'h10, 8'h02);
    hwr(5'h01, 8'h10);
    cyc(1, 0, 5'h01, 8'h20, 0, 1, 5'h01, '0, '0, 8'h10, "R8");
    check("R8 pending kept", {7'd0, l_irq_o}, 8'h01);
    lrd(5'h01, 8'h20, "R8");
    check("R7 irq after read", {7'd0, l_irq_o}, 8'h00);
    lrd(5'h11, 8'h01, "R7");

    hwr(5'h15, 8'hFF);
    hrd(5'h15, 8'h00, "R10");
    lrd(5'h1F, 8'h00, "R10");
    hrd(5'h10, 8'h04, "R10");

    repeat (3) @(negedge clk_i);
    check("queues drained", 8'(h_exp_q.size() + l_exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule